// File: doc/BRIEF.md
# Rotating Round Queue Scheduler

This block holds packet descriptors in a sorted order that is only approximate. It does this with a small, fixed set of FIFO queues, and each queue stands for one coarse transmission round. Upstream logic presents a descriptor together with the flow's running byte total. The block shifts that total right by a runtime exponent, so a round is worth a power-of-two number of bytes, and the result is the packet's departure round. The descriptor is then written into the queue whose index is that round modulo the queue count.

The dequeue side always serves the queue of the current round. When that queue runs dry and some other queue still holds work, the shared round counter steps forward by one. The queue that was just emptied falls to the back of the rotation and now stands for the round that lies a full queue count ahead. Upstream logic sees the current round on an output port, so no separate handshake is needed to keep the two sides in step.

A descriptor is dropped, and a one-cycle pulse is raised, in two cases: its round is too far in the future to be held, or its target queue is full.

Top module: `rsp_sched`

## Requirements
- R1: After reset, cur_round_o is 0, deq_valid_o is 0 and drop_o is 0.
- R2: The departure round is enq_bytes_i shifted right by bpr_shift_i bits. The descriptor goes into queue (round mod NUM_Q). Descriptors of one round leave in arrival order.
- R3: A descriptor whose departure round is below cur_round_o is placed in the queue of cur_round_o.
- R4: A descriptor whose departure round is at or above cur_round_o + NUM_Q is not stored. drop_o is 1 for exactly the cycle after that enqueue.
- R5: A descriptor whose target queue already holds FIFO_DEPTH entries, counted before that cycle's dequeue, is not stored, and drop_o pulses as in R4.
- R6: deq_valid_o is 1 exactly when the queue of cur_round_o is non-empty. deq_desc_o shows the oldest entry of that queue, and a cycle with deq_valid_o and deq_ready_i removes it.
- R7: cur_round_o increments by exactly 1 at a clock edge if, after that cycle's dequeue and enqueue, the current queue is empty and another queue held an entry before the edge. Otherwise cur_round_o holds.
- R8: After an advance, the queue that was just drained accepts the round cur_round_o + NUM_Q - 1 and serves it once the rotation reaches that round.
- R9: An enqueue and a dequeue on the current queue in the same cycle both complete, and the round does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_desc_i | input | DESC_W | Packet descriptor |
| enq_bytes_i | input | BYTE_W | Flow's cumulative byte estimate |
| bpr_shift_i | input | SHIFT_W | log2 of the bytes-per-round quantum |
| deq_ready_i | input | 1 | Downstream takes the head descriptor |
| deq_valid_o | output | 1 | Current-round queue is non-empty |
| deq_desc_o | output | DESC_W | Head descriptor of the current-round queue |
| cur_round_o | output | BYTE_W | Current round number |
| drop_o | output | 1 | Pulse: previous cycle's enqueue was discarded |

## Verification
Several descriptors are written into two rounds in mixed order. The order they come out in shows whether sorting happens by round and whether FIFO order holds inside a round. Late, in-window and too-distant rounds are then enqueued, which separates clamping, wrap-around placement in a recycled queue, and the far-round drop. A full queue, a head queue that is held without being served while other work is pending, and a same-cycle enqueue and dequeue on the head queue show, in that order, the capacity drop, the guard on round advance, and how simultaneous traffic is ordered. A change of the shift exponent confirms that the quantum is applied at run time.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    ENQ_NONE    = 2'd0,
    ENQ_TAKE    = 2'd1,
    ENQ_TOO_FAR = 2'd2
  } enq_verdict_e;
endpackage

// File: rtl/rsp_fifo.sv
module rsp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc_ptr(wr_q);
      if (pop_i)  rd_q <= inc_ptr(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rsp_round_map.sv
module rsp_round_map
  import rsp_pkg::*;
#(
  parameter int NUM_Q   = 32,
  parameter int BYTE_W  = 32,
  parameter int SHIFT_W = 5,
  localparam int QW     = $clog2(NUM_Q)
) (
  input  logic               valid_i,
  input  logic [BYTE_W-1:0]  bytes_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [BYTE_W-1:0]  cur_round_i,
  output enq_verdict_e       verdict_o,
  output logic [QW-1:0]      qidx_o
);
  logic [BYTE_W-1:0] pkt_round, tgt_round;
  logic [BYTE_W:0]   horizon;

  always_comb begin
    pkt_round = bytes_i >> shift_i;
    horizon   = {1'b0, cur_round_i} + (BYTE_W+1)'(NUM_Q);
    // late packets are clamped to the round being served
    tgt_round = (pkt_round < cur_round_i) ? cur_round_i : pkt_round;
    qidx_o    = tgt_round[QW-1:0];
    if (!valid_i)                         verdict_o = ENQ_NONE;
    else if ({1'b0, tgt_round} >= horizon) verdict_o = ENQ_TOO_FAR;
    else                                   verdict_o = ENQ_TAKE;
  end
endmodule

// File: rtl/rsp_round_ctrl.sv
module rsp_round_ctrl #(
  parameter int BYTE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_empty_next_i,
  input  logic              others_pending_i,
  output logic [BYTE_W-1:0] cur_round_o
);
  logic [BYTE_W-1:0] round_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   round_q <= '0;
    else if (head_empty_next_i && others_pending_i) round_q <= round_q + BYTE_W'(1);
  end

  assign cur_round_o = round_q;

  // R7
  round_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (round_q == $past(round_q)) || (round_q == $past(round_q) + BYTE_W'(1)));
endmodule

// File: rtl/rsp_sched.sv
module rsp_sched
  import rsp_pkg::*;
#(
  parameter int NUM_Q      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int DESC_W     = 16,
  parameter int BYTE_W     = 32,
  parameter int SHIFT_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enq_valid_i,
  input  logic [DESC_W-1:0]  enq_desc_i,
  input  logic [BYTE_W-1:0]  enq_bytes_i,
  input  logic [SHIFT_W-1:0] bpr_shift_i,
  input  logic               deq_ready_i,
  output logic               deq_valid_o,
  output logic [DESC_W-1:0]  deq_desc_o,
  output logic [BYTE_W-1:0]  cur_round_o,
  output logic               drop_o
);
  localparam int QW = $clog2(NUM_Q);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  enq_verdict_e      verdict;
  logic [QW-1:0]     enq_idx, head_idx;
  logic [BYTE_W-1:0] cur_round;
  logic [NUM_Q-1:0]  q_full, q_empty, q_push, q_pop;
  logic [DESC_W-1:0] q_data [NUM_Q];
  logic [CW-1:0]     q_cnt  [NUM_Q];
  logic              take, pop, push_head, head_empty_next, others_pending;
  logic [CW:0]       head_cnt_next;
  logic              drop_q;

  rsp_round_map #(.NUM_Q(NUM_Q), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_map (
    .valid_i    (enq_valid_i),
    .bytes_i    (enq_bytes_i),
    .shift_i    (bpr_shift_i),
    .cur_round_i(cur_round),
    .verdict_o  (verdict),
    .qidx_o     (enq_idx)
  );

  assign head_idx    = cur_round[QW-1:0];
  assign take        = (verdict == ENQ_TAKE) && !q_full[enq_idx];
  assign deq_valid_o = !q_empty[head_idx];
  assign deq_desc_o  = q_data[head_idx];
  assign pop         = deq_valid_o && deq_ready_i;
  assign push_head   = take && (enq_idx == head_idx);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign q_push[g] = take && (enq_idx == QW'(g));
    assign q_pop[g]  = pop && (head_idx == QW'(g));
    rsp_fifo #(.DW(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (q_push[g]),
      .wdata_i(enq_desc_i),
      .pop_i  (q_pop[g]),
      .rdata_o(q_data[g]),
      .cnt_o  (q_cnt[g]),
      .full_o (q_full[g]),
      .empty_o(q_empty[g])
    );
  end

  // advance decision uses the head occupancy after this cycle's traffic
  always_comb begin
    head_cnt_next   = {1'b0, q_cnt[head_idx]} + (CW+1)'(push_head) - (CW+1)'(pop);
    head_empty_next = (head_cnt_next == '0);
    others_pending  = 1'b0;
    for (int i = 0; i < NUM_Q; i++)
      if (QW'(i) != head_idx && !q_empty[i]) others_pending = 1'b1;
  end

  rsp_round_ctrl #(.BYTE_W(BYTE_W)) u_round (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .head_empty_next_i(head_empty_next),
    .others_pending_i (others_pending),
    .cur_round_o      (cur_round)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= enq_valid_i && !take;
  end

  assign cur_round_o = cur_round;
  assign drop_o      = drop_q;

  // R4
  drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict == ENQ_TOO_FAR) |=> drop_o);
  // R7
  hold_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i) |=> $stable(cur_round_o));
  // R9
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && push_head) |=> (deq_valid_o && $stable(cur_round_o)));
  // R2
  one_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_push));
endmodule

// File: tb/tb_rsp_sched.sv
module tb_rsp_sched;
  localparam int CLK_PERIOD = 10;
  localparam int K = 4, DEPTH = 2, DW = 8, BW = 16, SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0;
  logic [DW-1:0] enq_desc = '0;
  logic [BW-1:0] enq_bytes = '0;
  logic [SW-1:0] shift = SW'(4);
  logic          deq_ready = 1'b0;
  logic          deq_valid, drop;
  logic [DW-1:0] deq_desc;
  logic [BW-1:0] cur_round;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_sched #(.NUM_Q(K), .FIFO_DEPTH(DEPTH), .DESC_W(DW), .BYTE_W(BW), .SHIFT_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enq_valid_i(enq_valid), .enq_desc_i(enq_desc),
    .enq_bytes_i(enq_bytes), .bpr_shift_i(shift), .deq_ready_i(deq_ready),
    .deq_valid_o(deq_valid), .deq_desc_o(deq_desc), .cur_round_o(cur_round), .drop_o(drop)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input logic [DW-1:0] d, input int bytes, output logic dropped);
    enq_valid = 1'b1; enq_desc = d; enq_bytes = BW'(bytes);
    @(negedge clk);
    enq_valid = 1'b0;
    dropped = drop;
  endtask

  task automatic deq(input string req, input logic [DW-1:0] exp_d);
    check(req, int'(deq_valid), 1);
    check(req, int'(deq_desc), int'(exp_d));
    deq_ready = 1'b1;
    @(negedge clk);
    deq_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", int'(cur_round), 0);
    check("R1", int'(deq_valid), 0);
    check("R1", int'(drop), 0);
  endtask

  task automatic t_order;
    logic dr;
    enq(8'hA1, 5, dr);  check("R2", int'(dr), 0);
    enq(8'hB1, 20, dr); check("R2", int'(dr), 0);
    enq(8'hC1, 8, dr);  check("R2", int'(dr), 0);
    check("R2", int'(cur_round), 0);
    deq("R2", 8'hA1);
    deq("R2", 8'hC1);
    check("R7", int'(cur_round), 1);
    deq("R6", 8'hB1);
    check("R7", int'(cur_round), 1);
    check("R6", int'(deq_valid), 0);
  endtask

  task automatic t_late;
    logic dr;
    enq(8'hD1, 3, dr);
    check("R3", int'(dr), 0);
    check("R3", int'(deq_valid), 1);
    check("R3", int'(cur_round), 1);
    deq("R3", 8'hD1);
    check("R3", int'(deq_valid), 0);
  endtask

  task automatic t_far_and_wrap;
    logic dr;
    enq(8'hEE, 80, dr);
    check("R4", int'(dr), 1);
    @(negedge clk);
    check("R4", int'(drop), 0);
    check("R4", int'(deq_valid), 0);
    enq(8'hE1, 64, dr);
    check("R8", int'(dr), 0);
    repeat (3) @(negedge clk);
    check("R8", int'(cur_round), 4);
    deq("R8", 8'hE1);
    check("R8", int'(cur_round), 4);
  endtask

  task automatic t_full;
    logic dr;
    enq(8'hF1, 64, dr); check("R5", int'(dr), 0);
    enq(8'hF2, 70, dr); check("R5", int'(dr), 0);
    enq(8'hF3, 75, dr); check("R5", int'(dr), 1);
    deq("R5", 8'hF1);
    deq("R5", 8'hF2);
    check("R5", int'(deq_valid), 0);
  endtask

  task automatic t_same_cycle;
    logic dr;
    enq(8'h91, 64, dr);
    enq_valid = 1'b1; enq_desc = 8'h92; enq_bytes = BW'(70); deq_ready = 1'b1;
    check("R9", int'(deq_desc), 8'h91);
    @(negedge clk);
    enq_valid = 1'b0; deq_ready = 1'b0;
    check("R9", int'(drop), 0);
    check("R9", int'(cur_round), 4);
    deq("R9", 8'h92);
  endtask

  task automatic t_hold;
    logic dr;
    enq(8'h71, 64, dr);
    enq(8'h72, 80, dr);
    repeat (3) @(negedge clk);
    check("R7", int'(cur_round), 4);
    deq("R7", 8'h71);
    check("R7", int'(cur_round), 5);
    deq("R7", 8'h72);
    shift = SW'(5);
    enq(8'h73, 5*32 + 31, dr);
    check("R2", int'(dr), 0);
    deq("R2", 8'h73);
    check("R2", int'(cur_round), 5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_late();
        t_far_and_wrap();
        t_full();
        t_same_cycle();
        t_hold();
      end
      begin
        repeat (5000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule